// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block sits between a simple clocked request port and a 64K x 16 asynchronous static RAM. A user issues one read or write at a time with an address, write data, two byte enables and a direction flag; the controller then runs the memory's active-low strobes (chip enable, write enable, output enable, lower and upper byte select) through a fixed sequence and returns a one-clock ready pulse, together with the read data for a read.

Every memory timing minimum is given in nanoseconds and turned into whole clock cycles from a clock-period parameter, rounding up with a floor of one cycle. The controller counts the write pulse and the data setup, and it tracks how long output enable has been high, so that its own data drivers never overlap the memory's read drivers. The data bus is brought out as a split output, drive enable and input; the pad ring builds the tri-state.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and on release, chip enable, write enable, output enable and both byte selects are high, the data drive enable is low and ready is low.
- R2: A read accepted in idle holds chip enable and output enable low and write enable high for RD_CYC cycles (2 at the defaults, from the 12 ns access and cycle times at 10 ns); ready is high exactly RD_CYC+1 cycles after the accepting clock edge and carries the captured word.
- R3: On a read, a byte lane whose enable is 0 returns zero in the read data; lane 0 is bits 7:0, lane 1 is bits 15:8.
- R4: A write spends one setup cycle with chip enable low, then holds write enable low for WP_CYC cycles and keeps data driven through the pulse and one recovery cycle; ready follows the recovery, four cycles after acceptance at the defaults.
- R5: The lower byte select is low only when enable bit 0 is 1 and the upper only when bit 1 is 1, during an access only; a single-byte write leaves the other byte of that word unchanged.
- R6: The data drive enable is never high while output enable is low, and only after output enable has been high for at least TA_CYC cycles (ceiling of 6 ns over the period).
- R7: Output enable falls only in a cycle after one in which the controller did not drive the bus.
- R8: Ready is high for one cycle per request and only in idle; a request raised while an access is running is ignored.
- R9: A request with both byte enables 0 gives ready on the next cycle with no strobe asserted.
- R10: The memory address does not change while chip enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request, sampled only in idle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Write data |
| req_be_i | input | 2 | Byte enables, bit 0 low byte |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Read data, valid with ready |
| mem_addr_o | output | AW | Memory address |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_lb_n_o | output | 1 | Lower byte select, active low |
| mem_ub_n_o | output | 1 | Upper byte select, active low |
| mem_dq_o | output | DW | Data to memory |
| mem_dq_oe_o | output | 1 | Data drive enable |
| mem_dq_i | input | DW | Data from memory |

## Verification
Full-word writes and reads at several addresses check the strobe sequence, latency and data path, while low-only and high-only writes followed by full reads tell a correct lane gate apart from one that writes both bytes. Single-lane reads against a model that returns a filler pattern on unselected lanes show whether the unused lane is masked to zero. Writes straight after reads and reads straight after writes exercise bus turnaround, with a cycle monitor flagging any overlap of controller and memory drivers. A zero-enable request and a request raised mid-read separate correct early completion and busy rejection from a controller that starts a spurious access.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSET,
    ST_WPUL,
    ST_WREC
  } stc_state_e;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/stc_interval_cnt.sv
module stc_interval_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/stc_oe_tracker.sv
module stc_oe_tracker #(
  parameter int TA_CYC = 1,
  parameter int CW     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n_i,
  output logic settled_o
);
  localparam logic [CW-1:0] TA_MAX = CW'(TA_CYC);

  logic [CW-1:0] hi_q, hi_d;
  logic          hi_en;

  always_comb begin
    hi_en = !oe_n_i || (hi_q != TA_MAX);
    hi_d  = !oe_n_i ? '0 : hi_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= TA_MAX;
    else if (hi_en) hi_q <= hi_d;
  end

  assign settled_o = (hi_q == TA_MAX);

  p_settle_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_i |=> !settled_o);
endmodule

// File: rtl/stc_rd_capture.sv
module stc_rd_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic [1:0]    be_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] rdata_o
);
  localparam int LW = DW / 2;

  logic [DW-1:0] masked;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign masked[g*LW +: LW] = be_i[g] ? dq_i[g*LW +: LW] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_o <= '0;
    else if (cap_i) rdata_o <= masked;
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int CLK_NS   = 10,
  parameter int T_RC_NS  = 12,
  parameter int T_AA_NS  = 12,
  parameter int T_WC_NS  = 12,
  parameter int T_WP_NS  = 10,
  parameter int T_DW_NS  = 8,
  parameter int T_HZ_NS  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [1:0]    req_be_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_n_o,
  output logic          mem_we_n_o,
  output logic          mem_oe_n_o,
  output logic          mem_lb_n_o,
  output logic          mem_ub_n_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  import stc_pkg::*;

  localparam int CW      = 8;
  localparam int RD_CYC  = ns_to_cyc(max_u(T_RC_NS, T_AA_NS), CLK_NS);
  localparam int WP_CYC  = ns_to_cyc(max_u(T_WP_NS, T_DW_NS), CLK_NS);
  localparam int WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int REC_CYC = (WC_CYC > WP_CYC + 2) ? (WC_CYC - WP_CYC - 1) : 1;
  localparam int TA_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam logic [CW-1:0] RD_LD  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WP_LD  = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] REC_LD = CW'(REC_CYC - 1);

  stc_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [1:0]    be_q;
  logic          ready_q, ready_d;
  logic          take;
  logic          cnt_load;
  logic [CW-1:0] cnt_val;
  logic          cnt_last;
  logic          oe_settled;
  logic          cap;
  logic          active;

  stc_interval_cnt #(.CW(CW)) i_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(cnt_load), .load_val_i(cnt_val), .last_o(cnt_last)
  );

  stc_oe_tracker #(.TA_CYC(TA_CYC), .CW(CW)) i_oe_trk (
    .clk(clk), .rst_n(rst_n), .oe_n_i(mem_oe_n_o), .settled_o(oe_settled)
  );

  stc_rd_capture #(.DW(DW)) i_cap (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .be_i(be_q), .dq_i(mem_dq_i), .rdata_o(rdata_o)
  );

  // next-state and sequencing
  always_comb begin
    state_d  = state_q;
    ready_d  = 1'b0;
    take     = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    cap      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          take = 1'b1;
          if (req_be_i == 2'b00) begin
            ready_d = 1'b1;
          end else if (req_we_i) begin
            state_d = ST_WSET;
          end else begin
            state_d  = ST_RD;
            cnt_load = 1'b1;
            cnt_val  = RD_LD;
          end
        end
      end
      ST_RD: begin
        if (cnt_last) begin
          cap     = 1'b1;
          ready_d = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WSET: begin
        if (oe_settled) begin
          state_d  = ST_WPUL;
          cnt_load = 1'b1;
          cnt_val  = WP_LD;
        end
      end
      ST_WPUL: begin
        if (cnt_last) begin
          state_d  = ST_WREC;
          cnt_load = 1'b1;
          cnt_val  = REC_LD;
        end
      end
      ST_WREC: begin
        if (cnt_last) begin
          ready_d = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= ready_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (take) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      be_q    <= req_be_i;
    end
  end

  // strobe decode from registered state
  assign active      = (state_q != ST_IDLE);
  assign mem_ce_n_o  = !active;
  assign mem_oe_n_o  = (state_q != ST_RD);
  assign mem_we_n_o  = (state_q != ST_WPUL);
  assign mem_lb_n_o  = !(active && be_q[0]);
  assign mem_ub_n_o  = !(active && be_q[1]);
  assign mem_dq_oe_o = (state_q == ST_WPUL) || (state_q == ST_WREC);
  assign mem_dq_o    = wdata_q;
  assign mem_addr_o  = addr_q;
  assign ready_o     = ready_q;

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> (mem_ce_n_o && mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o && !ready_o));
  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe_o && !mem_oe_n_o));
  p_drive_settled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe_o |-> oe_settled);
  p_we_pulse_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n_o |-> (mem_dq_oe_o && !mem_ce_n_o));
  p_bs_inside_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n_o |-> (mem_lb_n_o && mem_ub_n_o));
  p_release_before_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n_o) |-> !$past(mem_dq_oe_o));
  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> mem_ce_n_o);
  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n_o && !$past(mem_ce_n_o)) |-> $stable(mem_addr_o));
  p_rw_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!mem_we_n_o, !mem_oe_n_o}));
endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;
  localparam int AW = 16;
  localparam int DW = 16;
  // Expected latencies at a 10 ns clock: read ceil(12/10)=2 cycles + ready = 3,
  // write setup 1 + pulse ceil(10/10)=1 + recovery 1 + ready = 4, empty = 1.
  localparam int LAT_RD = 3;
  localparam int LAT_WR = 4;
  localparam int TA     = 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req, req_we;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [1:0]    req_be;
  logic          ready;
  logic [DW-1:0] rdata;
  logic [AW-1:0] m_addr;
  logic          m_ce_n, m_we_n, m_oe_n, m_lb_n, m_ub_n, m_dq_oe;
  logic [DW-1:0] m_dq_o, m_dq_i;

  int errors = 0, checks = 0, mon_err = 0;
  logic [15:0] mem [0:255];
  logic [15:0] sb  [0:255];
  logic        mdrv;
  int          oe_hi;
  logic [AW-1:0] cur_addr;

  always #5 clk = ~clk;

  sram_async_ctrl i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_be_i(req_be), .ready_o(ready), .rdata_o(rdata),
    .mem_addr_o(m_addr), .mem_ce_n_o(m_ce_n), .mem_we_n_o(m_we_n), .mem_oe_n_o(m_oe_n),
    .mem_lb_n_o(m_lb_n), .mem_ub_n_o(m_ub_n), .mem_dq_o(m_dq_o), .mem_dq_oe_o(m_dq_oe),
    .mem_dq_i(m_dq_i)
  );

  // memory model: unselected lanes return a filler pattern
  always_comb begin
    mdrv   = !m_ce_n && !m_oe_n && m_we_n && (!m_lb_n || !m_ub_n);
    m_dq_i = 16'hA5A5;
    if (mdrv) begin
      if (!m_lb_n) m_dq_i[7:0]  = mem[m_addr[7:0]][7:0];
      if (!m_ub_n) m_dq_i[15:8] = mem[m_addr[7:0]][15:8];
    end
  end

  always @(posedge m_we_n) begin
    if (rst_n === 1'b1 && m_ce_n === 1'b0) begin
      if (!m_dq_oe) begin
        mon_err++;
        $display("FAIL R4: data not driven at write end act=%0b exp=1", m_dq_oe);
      end
      if (!m_lb_n) mem[m_addr[7:0]][7:0]  = m_dq_o[7:0];
      if (!m_ub_n) mem[m_addr[7:0]][15:8] = m_dq_o[15:8];
    end
  end

  // cycle monitor for contention, turnaround and address stability
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (m_dq_oe && mdrv) begin
        mon_err++;
        $display("FAIL R6: two drivers act=1 exp=0");
      end
      if (m_dq_oe && oe_hi < TA) begin
        mon_err++;
        $display("FAIL R6: drive after %0d oe-high cycles exp>=%0d", oe_hi, TA);
      end
      if (!m_ce_n && m_addr !== cur_addr) begin
        mon_err++;
        $display("FAIL R10: addr act=%h exp=%h", m_addr, cur_addr);
      end
      oe_hi = m_oe_n ? oe_hi + 1 : 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [1:0] be, output int lat);
    lat = 0;
    @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    cur_addr = a;
    do begin
      @(negedge clk);
      req = 1'b0;
      lat++;
    end while (!ready && lat < 50);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
    int lat;
    issue(1'b1, a, d, be, lat);
    chk(lat == LAT_WR, "R4 write latency", lat, LAT_WR);
    if (be[0]) sb[a[7:0]][7:0]  = d[7:0];
    if (be[1]) sb[a[7:0]][15:8] = d[15:8];
    chk(mem[a[7:0]] === sb[a[7:0]], "R5 stored word", mem[a[7:0]], sb[a[7:0]]);
    @(negedge clk);
    chk(!ready, "R8 ready one cycle", ready, 0);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input logic [1:0] be);
    int lat;
    logic [15:0] e;
    issue(1'b0, a, 16'h0, be, lat);
    e = sb[a[7:0]];
    if (!be[0]) e[7:0]  = 8'h00;
    if (!be[1]) e[15:8] = 8'h00;
    chk(lat == LAT_RD, "R2 read latency", lat, LAT_RD);
    chk(rdata === e, be == 2'b11 ? "R2 read data" : "R3 lane mask", rdata, e);
    @(negedge clk);
    chk(!ready, "R8 ready one cycle", ready, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(m_ce_n && m_we_n && m_oe_n && m_lb_n && m_ub_n && !m_dq_oe && !ready,
        "R1 reset strobes", {m_ce_n, m_we_n, m_oe_n, m_lb_n, m_ub_n, m_dq_oe, ready}, 7'b1111100);
  endtask

  task automatic t_empty();
    int lat;
    int strobes = 0;
    lat = 0;
    @(negedge clk);
    req = 1'b1; req_we = 1'b1; req_addr = 16'h0005; req_wdata = 16'hDEAD; req_be = 2'b00;
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    if (!m_ce_n || !m_lb_n || !m_ub_n || !m_we_n) strobes++;
    chk(ready, "R9 empty request ready", ready, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!m_ce_n || !m_we_n || !m_oe_n) strobes++;
    end
    chk(strobes == 0, "R9 no strobe", strobes, 0);
    chk(mem[5] === sb[5], "R9 memory untouched", mem[5], sb[5]);
  endtask

  task automatic t_busy();
    int lat = 0;
    int rdy = 0;
    @(negedge clk);
    req = 1'b1; req_we = 1'b0; req_addr = 16'h0010; req_be = 2'b11;
    cur_addr = 16'h0010;
    @(negedge clk);
    req = 1'b1; req_we = 1'b1; req_addr = 16'h0011; req_wdata = 16'hBAD0; req_be = 2'b11;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (ready) rdy++;
      if (!m_ce_n && i > 0) lat++;
    end
    chk(rdy == 1, "R8 busy request ignored ready count", rdy, 1);
    chk(lat == 0, "R8 no second access", lat, 0);
    chk(mem[8'h11] === sb[8'h11], "R8 busy write dropped", mem[8'h11], sb[8'h11]);
    chk(rdata === sb[8'h10], "R2 read during busy", rdata, sb[8'h10]);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'(i * 16'h0101 ^ 16'h3C00);
      sb[i]  = 16'(i * 16'h0101 ^ 16'h3C00);
    end
    rst_n = 1'b0; req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    oe_hi = 0; cur_addr = '0;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write(16'h0001, 16'h1234, 2'b11);
    t_read (16'h0001, 2'b11);
    t_write(16'h00FE, 16'hCAFE, 2'b11);
    t_write(16'h0001, 16'hAB77, 2'b01);   // R5 low only
    t_read (16'h0001, 2'b11);
    t_write(16'h0002, 16'h99EE, 2'b10);   // R5 high only
    t_read (16'h0002, 2'b11);
    t_read (16'h00FE, 2'b10);             // R3 low lane zero
    t_read (16'h00FE, 2'b01);             // R3 high lane zero
    t_write(16'h0003, 16'h0F0F, 2'b11);   // R7 write right after read
    t_read (16'h0003, 2'b11);             // R7 read right after write
    t_empty();
    t_busy();
    @(negedge clk);
    errors += mon_err;
    checks++;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors + mon_err, checks);
    $finish;
  end
endmodule